// File: doc/BRIEF.md
# Pause and Priority-Pause Request Sequencer

This controller drives a MAC's transmit flow-control interface once a data burst has gone out. It has two output vectors of NUM_CLASS+1 bits: a pause-enable vector and a pause-request vector. With the default NUM_CLASS of 8, bit 8 is the global (link-level) pause and bits 7 down to 0 are the priority classes. After a start pulse it runs two phases. In the first it requests a global pause and waits for the MAC to report that a pause frame went out. In the second it requests each priority class in turn, from the highest class to the lowest, and moves on only when the MAC reports the valid bit for that class. When the lowest class is acknowledged, all outputs return to zero and a one-cycle done strobe is issued.

Each wait step has a watchdog. A step that lasts 2^TMO_W cycles without its acknowledgement ends the run through the done state and sets a sticky error flag. A loss-of-alignment input aborts the run at any point, returns the block to idle with all outputs cleared and issues no done strobe. Quanta values and frame formation belong to the MAC and are not handled here.

Top module: `pause_seq_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows pause_en_o, pause_req_o, busy_o, done_o and timeout_err_o all at zero.
- R2: In idle, a start_i sampled high with link_lost_i low makes the next cycle show pause_en_o = 9'h100 and pause_req_o = 9'h100 (bit 8 = global pause) with busy_o high. It also clears timeout_err_o.
- R3: The global phase holds its outputs until pause_sent_i is sampled high. The next cycle then shows pause_en_o = 9'h0ff and pause_req_o = 9'h080 (class 7). pause_valid_i has no effect during the global phase.
- R4: In the priority phase exactly one request bit k (7..0) is high. It holds until pause_valid_i[k] is sampled high, and for k > 0 the next cycle shows only bit k-1. Valid bits of other classes and pause_sent_i have no effect in this phase.
- R5: When pause_valid_i[0] is sampled while class 0 is requested, the next cycle shows done_o high for exactly one cycle with both vectors zero and busy_o low. The cycle after that is idle.
- R6: If a wait step (the global phase or one class) lasts 2^TMO_W cycles with no acknowledgement, the next cycle is the done cycle with both vectors zero. timeout_err_o is then high and stays high until the next accepted start.
- R7: When link_lost_i is sampled high, the next cycle shows both vectors zero, busy_o low and done_o low. A start_i seen in the same cycle is not accepted.
- R8: start_i has no effect while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a sequence when the block is idle |
| link_lost_i | input | 1 | Loss of alignment; aborts the sequence |
| pause_sent_i | input | 1 | MAC status: a global pause frame was sent |
| pause_valid_i | input | NUM_CLASS+1 | MAC status: pause for a class is valid |
| pause_en_o | output | NUM_CLASS+1 | Pause-enable vector |
| pause_req_o | output | NUM_CLASS+1 | Pause-request vector |
| busy_o | output | 1 | High during the global phase and the priority phase |
| done_o | output | 1 | One-cycle completion strobe |
| timeout_err_o | output | 1 | Sticky flag: the last run ended by timeout |

## Verification
Each complete run is tried with several acknowledgement delays. While a step waits, the bench applies stray stimulus: every non-matching valid bit, pause_sent_i during the priority phase, and start_i again. This shows that a step advances only on its own acknowledgement. An abort is injected at each of the nine steps, which shows that the outputs clear in one cycle from any position in the walk. A timeout is forced at each of the nine steps, which checks that the counter restarts at each step boundary. It also checks that the error flag stays set and is cleared by the next start.

// File: rtl/pause_seq_pkg.sv
// Package: shared state encoding for the pause request sequencer.
// Assumes: all users import it; the encoding carries no external meaning.
package pause_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GLOBAL = 2'd1,
        ST_CLASS  = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pause_seq_timer.sv
// Module: per-step watchdog counter. It counts the cycles spent in one wait
// step and flags expiry on the 2^CNT_W-th cycle of that step.
// Assumes: clear_i is high whenever the step changes or no step is waiting.
module pause_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic expired_o
);
    logic [CNT_W-1:0] cnt_q;

    assign expired_o = &cnt_q;

    // Count up during a step; stop at the all-ones value; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !expired_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pause_seq_drive.sv
// Module: decodes the sequencer state and current class index into the
// pause-enable and pause-request vectors. Bit NUM_CLASS is the global
// pause; bits NUM_CLASS-1..0 are the priority classes.
// Assumes: idx_i is meaningful only in ST_CLASS.
module pause_seq_drive
    import pause_seq_pkg::*;
#(
    parameter int NUM_CLASS = 8,
    localparam int VEC_W = NUM_CLASS + 1,
    localparam int IDX_W = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1
) (
    input  seq_state_t       state_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [VEC_W-1:0] en_o,
    output logic [VEC_W-1:0] req_o
);
    logic in_global;
    logic in_class;

    assign in_global = (state_i == ST_GLOBAL);
    assign in_class  = (state_i == ST_CLASS);

    // Global pause bit: enabled and requested only in the first phase.
    assign en_o[NUM_CLASS]  = in_global;
    assign req_o[NUM_CLASS] = in_global;

    // One enable and one request per priority class.
    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_class
        assign en_o[g]  = in_class;
        assign req_o[g] = in_class && (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/pause_seq_ctrl.sv
// Module: top of the pause sequencer. It requests a global pause, waits for
// the sent status, then walks the priority classes from the highest to the
// lowest, waiting for each class's valid bit. On completion it clears all
// vectors and strobes done. A per-step watchdog ends a stalled run with an
// error flag. Loss of alignment aborts to idle.
// Assumes: status inputs are synchronous to clk.
module pause_seq_ctrl
    import pause_seq_pkg::*;
#(
    parameter int NUM_CLASS = 8,
    parameter int TMO_W     = 16,
    localparam int VEC_W = NUM_CLASS + 1,
    localparam int IDX_W = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             link_lost_i,
    input  logic             pause_sent_i,
    input  logic [VEC_W-1:0] pause_valid_i,
    output logic [VEC_W-1:0] pause_en_o,
    output logic [VEC_W-1:0] pause_req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_err_o
);
    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             err_q, err_d;
    logic             waiting;
    logic             advance;
    logic             expired;
    logic             accept;

    assign waiting = (state_q == ST_GLOBAL) || (state_q == ST_CLASS);
    assign accept  = (state_q == ST_IDLE) && start_i && !link_lost_i;

    // Next-state choice: abort first, then acknowledgement, then timeout.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        err_d   = err_q;
        if (link_lost_i) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_d = ST_GLOBAL;
                        err_d   = 1'b0;
                    end
                end
                ST_GLOBAL: begin
                    if (pause_sent_i) begin
                        state_d = ST_CLASS;
                        idx_d   = IDX_W'(NUM_CLASS - 1);
                    end else if (expired) begin
                        state_d = ST_DONE;
                        err_d   = 1'b1;
                    end
                end
                ST_CLASS: begin
                    if (pause_valid_i[idx_q]) begin
                        if (idx_q == '0) begin
                            state_d = ST_DONE;
                        end else begin
                            idx_d = idx_q - 1'b1;
                        end
                    end else if (expired) begin
                        state_d = ST_DONE;
                        err_d   = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // A step ends when either the state or the class index moves.
    assign advance = (state_d != state_q) || (idx_d != idx_q);

    // State, class index and sticky error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            err_q   <= err_d;
        end
    end

    pause_seq_timer #(
        .CNT_W (TMO_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (advance || !waiting),
        .expired_o (expired)
    );

    pause_seq_drive #(
        .NUM_CLASS (NUM_CLASS)
    ) u_drive (
        .state_i (state_q),
        .idx_i   (idx_q),
        .en_o    (pause_en_o),
        .req_o   (pause_req_o)
    );

    assign busy_o        = waiting;
    assign done_o        = (state_q == ST_DONE);
    assign timeout_err_o = err_q;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pause_req_o == '0 && !done_o && !timeout_err_o));
    p_start_global_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pause_req_o == (VEC_W'(1) << NUM_CLASS) && !timeout_err_o));
    p_global_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GLOBAL && !pause_sent_i && !expired && !link_lost_i)
        |=> $stable(pause_req_o));
    p_req_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pause_req_o));
    p_class_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLASS && !link_lost_i &&
         (|(pause_req_o[NUM_CLASS-1:1] & pause_valid_i[NUM_CLASS-1:1])))
        |=> (pause_req_o == ($past(pause_req_o) >> 1)));
    p_last_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLASS && pause_req_o[0] && pause_valid_i[0] && !link_lost_i)
        |=> (done_o && pause_req_o == '0 && pause_en_o == '0));
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_timeout_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && expired && !advance) |-> 1'b0);
    p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_lost_i |=> (pause_en_o == '0 && pause_req_o == '0 && !busy_o && !done_o));
    p_busy_nostart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !link_lost_i && !advance) |=> $stable(pause_req_o));
endmodule

// File: tb/tb_pause_seq_ctrl.sv
// Bench: sweeps acknowledgement delays, abort positions and timeout
// positions over a short-timeout build; expected vectors are computed from
// the step number.
module tb_pause_seq_ctrl;
    localparam int NC   = 8;
    localparam int TW   = 5;
    localparam int VW   = NC + 1;
    localparam int TLIM = 1 << TW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          link_lost_i = 1'b0;
    logic          pause_sent_i = 1'b0;
    logic [VW-1:0] pause_valid_i = '0;
    logic [VW-1:0] pause_en_o;
    logic [VW-1:0] pause_req_o;
    logic          busy_o;
    logic          done_o;
    logic          timeout_err_o;

    int n_chk = 0;
    int n_bad = 0;

    pause_seq_ctrl #(.NUM_CLASS(NC), .TMO_W(TW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .link_lost_i   (link_lost_i),
        .pause_sent_i  (pause_sent_i),
        .pause_valid_i (pause_valid_i),
        .pause_en_o    (pause_en_o),
        .pause_req_o   (pause_req_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .timeout_err_o (timeout_err_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [VW-1:0] exp_en(input int s);
        return (s == 0) ? (VW'(1) << NC) : ((VW'(1) << NC) - 1'b1);
    endfunction

    function automatic logic [VW-1:0] exp_req(input int s);
        return (s == 0) ? (VW'(1) << NC) : (VW'(1) << (NC - s));
    endfunction

    task automatic check_step(input string rq, input int s);
        chk(rq, "en", 32'(pause_en_o), 32'(exp_en(s)));
        chk(rq, "req", 32'(pause_req_o), 32'(exp_req(s)));
        chk(rq, "busy", 32'(busy_o), 32'd1);
        chk(rq, "done", 32'(done_o), 32'd0);
    endtask

    task automatic check_quiet(input string rq, input logic dn);
        chk(rq, "en", 32'(pause_en_o), 32'd0);
        chk(rq, "req", 32'(pause_req_o), 32'd0);
        chk(rq, "busy", 32'(busy_o), 32'd0);
        chk(rq, "done", 32'(done_o), 32'(dn));
    endtask

    // Stray stimulus that must not advance step s.
    task automatic stray_on(input int s);
        start_i = 1'b1;
        if (s == 0) begin
            pause_valid_i = '1;
        end else begin
            pause_sent_i  = 1'b1;
            pause_valid_i = ~(VW'(1) << (NC - s));
        end
    endtask

    task automatic stray_off;
        start_i       = 1'b0;
        pause_sent_i  = 1'b0;
        pause_valid_i = '0;
    endtask

    // mode 0: complete run, 1: abort at step 'at', 2: timeout at step 'at'.
    task automatic run(input int mode, input int at, input int dly);
        start_i = 1'b1;
        tick;
        start_i = 1'b0;
        chk("R2", "err cleared by start", 32'(timeout_err_o), 32'd0);
        for (int s = 0; s <= NC; s++) begin
            check_step((s == 0) ? "R2" : ((s == 1) ? "R3" : "R4"), s);
            if (mode == 1 && s == at) begin
                link_lost_i = 1'b1;
                tick;
                link_lost_i = 1'b0;
                check_quiet("R7", 1'b0);
                tick;
                check_quiet("R7", 1'b0);
                return;
            end
            if (mode == 2 && s == at) begin
                stray_on(s);
                repeat (TLIM - 1) tick;
                check_step("R6", s);
                tick;
                stray_off;
                check_quiet("R6", 1'b1);
                chk("R6", "err set", 32'(timeout_err_o), 32'd1);
                tick;
                check_quiet("R6", 1'b0);
                chk("R6", "err sticky", 32'(timeout_err_o), 32'd1);
                return;
            end
            stray_on(s);
            repeat ((dly + s) % 4) tick;
            stray_off;
            check_step("R8", s);
            if (s == 0) pause_sent_i = 1'b1;
            else        pause_valid_i = VW'(1) << (NC - s);
            tick;
            stray_off;
        end
        check_quiet("R5", 1'b1);
        chk("R5", "err", 32'(timeout_err_o), 32'd0);
        tick;
        check_quiet("R5", 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        start_i = 1'b1;
        repeat (3) tick;
        start_i = 1'b0;
        check_quiet("R1", 1'b0);
        chk("R1", "err", 32'(timeout_err_o), 32'd0);
        rst_n = 1'b1;
        tick;
        check_quiet("R1", 1'b0);

        // R7: start blocked while alignment is lost.
        link_lost_i = 1'b1;
        start_i     = 1'b1;
        tick;
        link_lost_i = 1'b0;
        start_i     = 1'b0;
        check_quiet("R7", 1'b0);

        for (int d = 0; d < 4; d++) run(0, 0, d);
        for (int a = 0; a <= NC; a++) run(1, a, a);
        for (int a = 0; a <= NC; a++) begin
            run(2, a, 0);
            run(0, 0, a);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule